// File: doc/BRIEF.md
# ATM Circuit Match Engine

The engine holds a small table of 64-bit entries and looks up an incoming cell's path and channel identifiers in all entries at once. Each entry carries a 32-bit key in its upper half and a 32-bit output word in its lower half. Within the key, bits 47:32 hold the channel identifier (VCI), bits 59:48 the path identifier (VPI) and bits 63:60 optional extra match bits. An entry whose VCI field is 16'hFFFF is a path entry. It matches any channel on its VPI. Every other entry is a channel entry and needs both identifiers to agree.

A search returns a one-cycle ready pulse together with the hit and path flags and the output word of the winning entry. A mask register lets the software side ignore key bits. One use is a path field narrowed to 8 bits. Table changes go through a small command port. While the ATM mode flag is set, insert and delete commands follow redirect rules, so that path and channel entries with the same VPI can share the table.

Top module: `atm_circuit_match`

## Requirements
- R1: After reset the table is empty, mode_o, rdy_o, hit_o and path_o are 0, word_o is 0, and the mask ignores key bits 31:28.
- R2: A command with cmd_op_i=1 sets mode_o and cmd_op_i=2 clears it, from the next cycle. A search made while mode_o is 0 reports no hit.
- R3: rdy_o is high in exactly the cycle after a cycle with srch_i high, and hit_o, path_o and word_o are valid with it.
- R4: key_i bit k is compared with entry bit 32+k: VCI on key bits 15:0, VPI on 27:16, extra bits on 31:28. A channel entry whose unmasked key bits all equal key_i gives hit_o=1, path_o=0 and word_o equal to the entry's bits 31:0.
- R5: A path entry (bits 47:32 equal 16'hFFFF) whose unmasked bits 63:48 equal key_i[31:16] gives hit_o=1 and path_o=1, with its output word.
- R6: A channel match wins over a path match. Among several entries of the same kind, the lowest table slot wins.
- R7: cmd_op_i=3 loads cmd_data_i[31:0] into the mask. Mask bit k set makes key bit k, and entry bit 32+k, a don't-care in searches.
- R8: A search with no match gives hit_o=0, path_o=0 and word_o=0.
- R9: cmd_op_i=4 inserts cmd_data_i. If an entry has exactly the same 32-bit key, it is overwritten. Otherwise the lowest free slot is used. When the table is full, the insert is dropped.
- R10: In ATM mode, inserting a channel entry whose bits 63:48 equal those of a stored path entry, with no exact-key entry present, overwrites that path entry.
- R11: cmd_op_i=5 deletes the entry whose key equals cmd_data_i[63:32] exactly.
- R12: In ATM mode, deleting a channel key that is absent removes a stored path entry with the same bits 63:48. With the mode clear, no such redirect happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (1 mode on, 2 mode off, 3 mask, 4 insert, 5 delete) |
| cmd_data_i | input | 64 | Entry for insert, key in 63:32 for delete, mask in 31:0 |
| srch_i | input | 1 | Search request |
| key_i | input | 32 | Search key: VCI 15:0, VPI 27:16, extra 31:28 |
| mode_o | output | 1 | ATM mode flag |
| rdy_o | output | 1 | Search result valid |
| hit_o | output | 1 | Match found |
| path_o | output | 1 | Match came from a path entry |
| word_o | output | 32 | Output word of the winning entry |

## Verification
The redirect cases are the hardest to set up from the ports. The delete redirect needs a path entry and an absent channel key with the same VPI. The priority case needs a channel entry and a path entry on the same VPI, which an insert in ATM mode would normally merge. The stimulus stores the channel entry first and the path entry after it, since inserting a path entry never redirects. Each removal is confirmed by a later search that misses. The full-table drop is reached by filling every slot with a distinct key.

// File: rtl/atm_match_pkg.sv
package atm_match_pkg;
  localparam int ENT_W  = 64;
  localparam int WORD_W = 32;
  localparam int KEY_W  = ENT_W - WORD_W;
  localparam int VCI_W  = 16;
  localparam logic [VCI_W-1:0] VCI_PATH = '1;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_MODE_ON  = 3'd1,
    OP_MODE_OFF = 3'd2,
    OP_MASK     = 3'd3,
    OP_INSERT   = 3'd4,
    OP_DELETE   = 3'd5
  } op_e;
endpackage

// File: rtl/atm_entry_cmp.sv
module atm_entry_cmp
  import atm_match_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] ign_i,
  output logic             full_eq_o,
  output logic             path_eq_o
);
  logic [KEY_W-1:0] diff;

  assign diff      = (entry_i[ENT_W-1:WORD_W] ^ key_i) & ~ign_i;
  assign full_eq_o = ~|diff;
  assign path_eq_o = ~|diff[KEY_W-1:VCI_W];
endmodule

// File: rtl/atm_prio_enc.sv
module atm_prio_enc #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  // R6: chosen slot must be a requesting slot
  always_comb begin
    if (any_o) a_r6_idx_requests: assert (req_i[idx_o]);
  end
endmodule

// File: rtl/atm_circuit_match.sv
module atm_circuit_match
  import atm_match_pkg::*;
#(
  parameter int               ENTRIES = 16,
  parameter logic [KEY_W-1:0] IGN_RST = 32'hF000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ENT_W-1:0]  cmd_data_i,
  input  logic              srch_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              mode_o,
  output logic              rdy_o,
  output logic              hit_o,
  output logic              path_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENT_W-1:0]   tbl_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   ign_q;
  logic               mode_q;

  logic [ENTRIES-1:0] isp, s_full, s_path, c_full, c_path;
  logic [ENTRIES-1:0] vcc_req, vpc_req, ex_req, vps_req;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign isp[g] = (tbl_q[g][WORD_W+VCI_W-1:WORD_W] == VCI_PATH);

    atm_entry_cmp u_srch (
      .entry_i  (tbl_q[g]),
      .key_i    (key_i),
      .ign_i    (ign_q),
      .full_eq_o(s_full[g]),
      .path_eq_o(s_path[g])
    );

    atm_entry_cmp u_cmd (
      .entry_i  (tbl_q[g]),
      .key_i    (cmd_data_i[ENT_W-1:WORD_W]),
      .ign_i    ('0),
      .full_eq_o(c_full[g]),
      .path_eq_o(c_path[g])
    );

    assign vcc_req[g] = vld_q[g] & ~isp[g] & s_full[g];
    assign vpc_req[g] = vld_q[g] &  isp[g] & s_path[g];
    assign ex_req[g]  = vld_q[g] & c_full[g];
    assign vps_req[g] = vld_q[g] & isp[g] & c_path[g];
  end

  logic          vcc_any, vpc_any, ex_any, vps_any, free_any;
  logic [IW-1:0] vcc_idx, vpc_idx, ex_idx, vps_idx, free_idx;

  atm_prio_enc #(.N(ENTRIES)) u_vcc  (.req_i(vcc_req), .any_o(vcc_any),  .idx_o(vcc_idx));
  atm_prio_enc #(.N(ENTRIES)) u_vpc  (.req_i(vpc_req), .any_o(vpc_any),  .idx_o(vpc_idx));
  atm_prio_enc #(.N(ENTRIES)) u_ex   (.req_i(ex_req),  .any_o(ex_any),   .idx_o(ex_idx));
  atm_prio_enc #(.N(ENTRIES)) u_vps  (.req_i(vps_req), .any_o(vps_any),  .idx_o(vps_idx));
  atm_prio_enc #(.N(ENTRIES)) u_free (.req_i(~vld_q),  .any_o(free_any), .idx_o(free_idx));

  op_e           op;
  logic          new_isp;
  logic          ins_en, del_en;
  logic [IW-1:0] ins_idx, del_idx;

  assign op      = op_e'(cmd_op_i);
  assign new_isp = (cmd_data_i[WORD_W+VCI_W-1:WORD_W] == VCI_PATH);

  always_comb begin
    ins_en  = 1'b1;
    ins_idx = free_idx;
    if (ex_any)                           ins_idx = ex_idx;
    else if (mode_q && !new_isp && vps_any) ins_idx = vps_idx;
    else if (!free_any)                   ins_en  = 1'b0;
  end

  always_comb begin
    del_en  = 1'b0;
    del_idx = ex_idx;
    if (ex_any) begin
      del_en = 1'b1;
    end else if (mode_q && !new_isp && vps_any) begin
      del_en  = 1'b1;
      del_idx = vps_idx;
    end
  end

  logic do_ins, do_del;
  assign do_ins = cmd_vld_i && (op == OP_INSERT) && ins_en;
  assign do_del = cmd_vld_i && (op == OP_DELETE) && del_en;

  always_ff @(posedge clk_i) begin
    if (do_ins) tbl_q[ins_idx] <= cmd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      ign_q  <= IGN_RST;
      mode_q <= 1'b0;
    end else begin
      if (do_ins) vld_q[ins_idx] <= 1'b1;
      if (do_del) vld_q[del_idx] <= 1'b0;
      if (cmd_vld_i) begin
        case (op)
          OP_MODE_ON:  mode_q <= 1'b1;
          OP_MODE_OFF: mode_q <= 1'b0;
          OP_MASK:     ign_q  <= cmd_data_i[KEY_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Search result stage
  logic          s_hit;
  logic [IW-1:0] s_idx;
  logic          rdy_q, hit_q, path_q;
  logic [WORD_W-1:0] word_q;

  assign s_hit = srch_i && mode_q && (vcc_any || vpc_any);
  assign s_idx = vcc_any ? vcc_idx : vpc_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      hit_q  <= 1'b0;
      path_q <= 1'b0;
      word_q <= '0;
    end else begin
      rdy_q  <= srch_i;
      hit_q  <= s_hit;
      path_q <= s_hit && !vcc_any;
      word_q <= s_hit ? tbl_q[s_idx][WORD_W-1:0] : '0;
    end
  end

  assign mode_o = mode_q;
  assign rdy_o  = rdy_q;
  assign hit_o  = hit_q;
  assign path_o = path_q;
  assign word_o = word_q;

  a_r3_hit_with_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rdy_o);
  a_r2_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch_i && !mode_o) |=> !hit_o);
  a_r2_mode_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_op_i == 3'd1) |=> mode_o);
  a_r2_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_op_i == 3'd2) |=> !mode_o);
  a_r5_path_is_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_o |-> hit_o);
  a_r8_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !hit_o) |-> (word_o == '0 && !path_o));
endmodule

// File: tb/atm_circuit_match_test.sv
`timescale 1ns/1ps
module atm_circuit_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_data = '0;
  logic        srch = 1'b0;
  logic [31:0] key = '0;
  logic        mode, rdy, hit, path;
  logic [31:0] word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  atm_circuit_match uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .srch_i(srch), .key_i(key), .mode_o(mode),
    .rdy_o(rdy), .hit_o(hit), .path_o(path), .word_o(word)
  );

  function automatic logic [31:0] k(logic [3:0] x, logic [11:0] vpi, logic [15:0] vci);
    return {x, vpi, vci};
  endfunction

  function automatic logic [63:0] e(logic [3:0] x, logic [11:0] vpi, logic [15:0] vci,
                                    logic [31:0] w);
    return {x, vpi, vci, w};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(logic [2:0] op, logic [63:0] d);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 3'd0; cmd_data = '0;
  endtask

  // search, then compare {rdy,hit,path,word}
  task automatic look(string req, logic [31:0] kk, logic h, logic p, logic [31:0] w);
    @(negedge clk);
    srch = 1'b1; key = kk;
    @(negedge clk);
    srch = 1'b0;
    chk(req, {29'd0, rdy, hit, path, word}, {29'd0, 1'b1, h, p, w});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset outputs", {59'd0, mode, rdy, hit, path, |word}, 64'd0);
    cmd(3'd1, '0);
    cmd(3'd4, e(4'h0, 12'h011, 16'h0022, 32'hAAAA_0001));
    look("R1 reset mask ignores 31:28", k(4'hA, 12'h011, 16'h0022), 1, 0, 32'hAAAA_0001);
    @(negedge clk);
    chk("R3 rdy single pulse", {63'd0, rdy}, 64'd0);
  endtask

  task automatic t_mode();
    do_reset();
    cmd(3'd4, e(4'h0, 12'h021, 16'h0031, 32'h0000_0B0B));
    look("R2 mode clear no hit", k(4'h0, 12'h021, 16'h0031), 0, 0, 32'h0);
    cmd(3'd1, '0);
    chk("R2 mode set", {63'd0, mode}, 64'd1);
    look("R2 hit once mode set", k(4'h0, 12'h021, 16'h0031), 1, 0, 32'h0000_0B0B);
    cmd(3'd2, '0);
    chk("R2 mode clear", {63'd0, mode}, 64'd0);
  endtask

  task automatic t_match();
    do_reset();
    cmd(3'd1, '0);
    cmd(3'd3, 64'd0);
    cmd(3'd4, e(4'h0, 12'h123, 16'h4567, 32'hC0DE_0001));
    cmd(3'd4, e(4'h5, 12'h0F0, 16'hFFFF, 32'hC0DE_0002));
    look("R4 channel match", k(4'h0, 12'h123, 16'h4567), 1, 0, 32'hC0DE_0001);
    look("R8 channel vci miss", k(4'h0, 12'h123, 16'h4568), 0, 0, 32'h0);
    look("R4 extra bits compared", k(4'h1, 12'h123, 16'h4567), 0, 0, 32'h0);
    look("R5 path match", k(4'h5, 12'h0F0, 16'h1234), 1, 1, 32'hC0DE_0002);
    look("R8 path vpi miss", k(4'h5, 12'h0F1, 16'h1234), 0, 0, 32'h0);
  endtask

  task automatic t_prio_mask();
    do_reset();
    cmd(3'd1, '0);
    cmd(3'd4, e(4'h0, 12'h044, 16'h0100, 32'h0000_00A1));
    cmd(3'd4, e(4'h0, 12'h044, 16'hFFFF, 32'h0000_00A2));
    look("R6 channel beats path", k(4'h0, 12'h044, 16'h0100), 1, 0, 32'h0000_00A1);
    look("R5 path on other vci", k(4'h0, 12'h044, 16'h0200), 1, 1, 32'h0000_00A2);
    cmd(3'd4, e(4'h0, 12'h077, 16'h0010, 32'h0000_00B0));
    cmd(3'd4, e(4'h0, 12'h077, 16'h0011, 32'h0000_00B1));
    look("R4 second entry exact", k(4'h0, 12'h077, 16'h0011), 1, 0, 32'h0000_00B1);
    cmd(3'd3, 64'h0000_0000_0000_0001);
    look("R6 lowest slot wins", k(4'h0, 12'h077, 16'h0011), 1, 0, 32'h0000_00B0);
    cmd(3'd3, 64'h0000_0000_0F00_0000);
    look("R7 narrow vpi mask", k(4'h0, 12'h944, 16'h0100), 1, 0, 32'h0000_00A1);
    cmd(3'd3, 64'd0);
    look("R7 cleared mask compares 31:28", k(4'h3, 12'h044, 16'h0100), 0, 0, 32'h0);
  endtask

  task automatic t_insert();
    do_reset();
    cmd(3'd1, '0);
    cmd(3'd4, e(4'h0, 12'h0AB, 16'h0CD, 32'h1111_1111));
    cmd(3'd4, e(4'h0, 12'h0AB, 16'h0CD, 32'h2222_2222));
    look("R9 exact key overwrite", k(4'h0, 12'h0AB, 16'h0CD), 1, 0, 32'h2222_2222);
    do_reset();
    cmd(3'd1, '0);
    for (int i = 0; i < 16; i++)
      cmd(3'd4, e(4'h0, 12'(i + 1), 16'h0001, 32'(i + 32'h100)));
    cmd(3'd4, e(4'h0, 12'h200, 16'h0001, 32'h0000_0999));
    look("R9 full table drops insert", k(4'h0, 12'h200, 16'h0001), 0, 0, 32'h0);
    look("R9 last slot kept", k(4'h0, 12'd16, 16'h0001), 1, 0, 32'h0000_010F);
    cmd(3'd5, e(4'h0, 12'd3, 16'h0001, 32'h0));
    cmd(3'd4, e(4'h0, 12'h200, 16'h0001, 32'h0000_0999));
    look("R9 freed slot reused", k(4'h0, 12'h200, 16'h0001), 1, 0, 32'h0000_0999);
  endtask

  task automatic t_redirect();
    do_reset();
    cmd(3'd1, '0);
    cmd(3'd4, e(4'h0, 12'h055, 16'hFFFF, 32'h0000_0051));
    cmd(3'd4, e(4'h0, 12'h055, 16'h0007, 32'h0000_0052));
    look("R10 vcc replaced path", k(4'h0, 12'h055, 16'h0009), 0, 0, 32'h0);
    look("R10 vcc present", k(4'h0, 12'h055, 16'h0007), 1, 0, 32'h0000_0052);
    cmd(3'd4, e(4'h0, 12'h033, 16'h0004, 32'h0000_0033));
    cmd(3'd5, e(4'h0, 12'h033, 16'h0004, 32'h0));
    look("R11 exact delete", k(4'h0, 12'h033, 16'h0004), 0, 0, 32'h0);
    // mode clear: no delete redirect
    cmd(3'd2, '0);
    cmd(3'd4, e(4'h0, 12'h066, 16'hFFFF, 32'h0000_0066));
    cmd(3'd5, e(4'h0, 12'h066, 16'h0010, 32'h0));
    cmd(3'd1, '0);
    look("R12 no redirect with mode clear", k(4'h0, 12'h066, 16'h0020), 1, 1, 32'h0000_0066);
    cmd(3'd5, e(4'h0, 12'h066, 16'h0010, 32'h0));
    look("R12 absent vcc deletes path", k(4'h0, 12'h066, 16'h0020), 0, 0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode();
    t_match();
    t_prio_mask();
    t_insert();
    t_redirect();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule